// File: doc/BRIEF.md
# Reorder buffer commit unit

This block is the in-order retirement stage of a speculative out-of-order core. Each instruction is given a slot in a circular buffer when it is dispatched, and the slot number goes back to the front end as the instruction's result tag. Execution units may finish in any order. When one finishes, it writes the result value into the slot named by its tag, and for a branch it also reports whether the branch was mispredicted. Slots leave the buffer from the oldest end only, and only after they are marked finished. A retired slot updates a commit-side register file that holds nothing except retired results.

The block keeps a second, issue-side view of the registers for the dispatch stage. For each architectural register this view records whether a result is still in flight and which slot will produce it. A single lookup port returns the operand from that slot if the slot has finished, or from the commit-side file if no result is in flight. When a mispredicted branch reaches the oldest position, it retires and raises a flush. The flush discards every younger slot and makes the issue-side view fall back to the commit-side file. The next slot handed out is the one just after the branch.

Top module: `rob_commit_unit`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready_o`=1, `alloc_tag_o`=0, `commit_valid_o`=0 and `flush_o`=0. Every register looks up as ready with value 0.
- R2: Accepted allocations get tags 0,1,2,… in dispatch order, counting modulo DEPTH. `alloc_tag_o` shows the tag that the next accepted allocation will receive.
- R3: When DEPTH slots are held, `alloc_ready_o`=0. An allocation request in that state is ignored: it changes neither the next tag nor the issue-side view of its destination.
- R4: An entry retires only when it is the oldest and is finished. At most one entry retires per cycle, in tag order. Finished younger entries wait behind an unfinished older entry.
- R5: A retiring entry drives `commit_valid_o`=1 with its tag, destination and value. `commit_wen_o`=1 for a register-writing entry and 0 for a branch.
- R6: A register-writing entry updates the commit-side file as it retires. A lookup of that register returns the value once no younger producer of that register is in flight.
- R7: After allocation to register r, a lookup of r returns ready=0 with the producer's tag. Once the producer finishes, the lookup returns ready=1 with the finished value, even before the producer retires.
- R8: When several in-flight entries write the same register, the lookup names the youngest. Retiring an older one leaves that mapping in place.
- R9: A finished branch marked mispredicted raises `flush_o` in the cycle it retires, with `commit_wen_o`=0. Every younger entry is discarded and never retires. All registers then look up as ready with their commit-side values. The next allocation tag is the branch's tag plus 1.
- R10: A finished branch that is not mispredicted retires without `flush_o`, and the following tags continue in sequence.
- R11: In the cycle `flush_o` is high, `alloc_ready_o` is 0, so no allocation is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Dispatch requests a slot |
| alloc_dst_i | input | AW | Destination register of the dispatched instruction |
| alloc_branch_i | input | 1 | Dispatched instruction is a branch (writes no register) |
| alloc_ready_o | output | 1 | A slot can be taken this cycle |
| alloc_tag_o | output | TW | Tag given to an allocation accepted this cycle |
| cpl_valid_i | input | 1 | An execution result is written back |
| cpl_tag_i | input | TW | Slot the result belongs to |
| cpl_value_i | input | DW | Result value |
| cpl_mispredict_i | input | 1 | Branch outcome differed from the prediction |
| src_reg_i | input | AW | Register to look up in the issue-side view |
| src_ready_o | output | 1 | Operand value is available |
| src_tag_o | output | TW | Producing slot when a result is in flight |
| src_value_o | output | DW | Operand value when ready |
| commit_valid_o | output | 1 | The oldest entry retires this cycle |
| commit_wen_o | output | 1 | The retiring entry writes a register |
| commit_dst_o | output | AW | Destination of the retiring entry |
| commit_tag_o | output | TW | Tag of the retiring entry |
| commit_value_o | output | DW | Value of the retiring entry |
| flush_o | output | 1 | Mispredicted branch retires; younger work is dropped |

## Verification
A head pointer that skips or repeats shows at once as a retiring tag out of order, or as a retired value or destination that does not match the dispatched instruction. A wrong tail shows at the very next allocation as an unexpected tag. A stale issue-side mapping shows on the lookup port: after a retirement or a flush, the register stays not-ready, or it returns a value that was discarded. A flush that misses a younger entry shows within a few cycles, because that entry retires although it should not exist. A wrong full test shows as refused or extra allocations exactly at the DEPTH boundary.

// File: rtl/rob_pkg.sv
package rob_pkg;

    // Classification of what the oldest entry does this cycle
    typedef enum logic [1:0] {
        RET_NONE   = 2'd0,
        RET_REG    = 2'd1,
        RET_BRANCH = 2'd2,
        RET_FLUSH  = 2'd3
    } ret_kind_e;

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
    parameter int DEPTH = 8,
    parameter int TW    = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          alloc_i,
    input  logic          retire_i,
    input  logic          flush_i,
    output logic [TW-1:0] head_idx_o,
    output logic [TW-1:0] tail_idx_o,
    output logic          full_o
);

    // Pointers carry one extra wrap bit above the slot index
    typedef struct packed {
        logic [TW:0] head;
        logic [TW:0] tail;
    } ptr_t;

    ptr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            // branch at the head retires, everything younger is dropped
            st_d.head = st_q.head + 1'b1;
            st_d.tail = st_q.head + 1'b1;
        end else begin
            if (alloc_i)  st_d.tail = st_q.tail + 1'b1;
            if (retire_i) st_d.head = st_q.head + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign head_idx_o = st_q.head[TW-1:0];
    assign tail_idx_o = st_q.tail[TW-1:0];
    assign full_o     = (st_q.head[TW] != st_q.tail[TW]) &&
                        (st_q.head[TW-1:0] == st_q.tail[TW-1:0]);

endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array #(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    parameter int AW    = 4,
    parameter int TW    = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          flush_i,
    input  logic          alloc_i,
    input  logic [TW-1:0] alloc_idx_i,
    input  logic [AW-1:0] alloc_dst_i,
    input  logic          alloc_branch_i,
    input  logic          cpl_i,
    input  logic [TW-1:0] cpl_idx_i,
    input  logic [DW-1:0] cpl_value_i,
    input  logic          cpl_mispredict_i,
    input  logic          retire_i,
    input  logic [TW-1:0] head_idx_i,
    output logic          head_valid_o,
    output logic          head_done_o,
    output logic          head_branch_o,
    output logic          head_mispred_o,
    output logic [AW-1:0] head_dst_o,
    output logic [DW-1:0] head_value_o,
    input  logic [TW-1:0] rd_idx_i,
    output logic          rd_done_o,
    output logic [DW-1:0] rd_value_o
);

    typedef struct packed {
        logic          valid;
        logic          done;
        logic          branch;
        logic          mispred;
        logic [AW-1:0] dst;
        logic [DW-1:0] value;
    } ent_t;

    ent_t ent_arr [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        ent_t e_d, e_q;

        always_comb begin
            e_d = e_q;
            if (flush_i) begin
                e_d.valid = 1'b0;
            end else begin
                if (alloc_i && alloc_idx_i == TW'(g)) begin
                    e_d.valid   = 1'b1;
                    e_d.done    = 1'b0;
                    e_d.branch  = alloc_branch_i;
                    e_d.mispred = 1'b0;
                    e_d.dst     = alloc_dst_i;
                    e_d.value   = '0;
                end
                if (cpl_i && e_q.valid && cpl_idx_i == TW'(g)) begin
                    e_d.done    = 1'b1;
                    e_d.value   = cpl_value_i;
                    e_d.mispred = cpl_mispredict_i;
                end
                if (retire_i && head_idx_i == TW'(g)) begin
                    e_d.valid = 1'b0;
                end
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) e_q <= '0;
            else         e_q <= e_d;
        end

        assign ent_arr[g] = e_q;
    end

    ent_t head_ent, rd_ent;
    assign head_ent = ent_arr[head_idx_i];
    assign rd_ent   = ent_arr[rd_idx_i];

    assign head_valid_o   = head_ent.valid;
    assign head_done_o    = head_ent.done;
    assign head_branch_o  = head_ent.branch;
    assign head_mispred_o = head_ent.mispred;
    assign head_dst_o     = head_ent.dst;
    assign head_value_o   = head_ent.value;
    assign rd_done_o      = rd_ent.valid && rd_ent.done;
    assign rd_value_o     = rd_ent.value;

endmodule

// File: rtl/rob_reg_views.sv
module rob_reg_views #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    parameter int TW   = 3,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          flush_i,
    input  logic          map_i,
    input  logic [AW-1:0] map_dst_i,
    input  logic [TW-1:0] map_tag_i,
    input  logic          ret_we_i,
    input  logic [AW-1:0] ret_dst_i,
    input  logic [TW-1:0] ret_tag_i,
    input  logic [DW-1:0] ret_value_i,
    input  logic [AW-1:0] rd_reg_i,
    output logic          rd_pending_o,
    output logic [TW-1:0] rd_tag_o,
    output logic [DW-1:0] rd_arch_o
);

    // Issue-side map (pending + producer tag) and commit-side file
    typedef struct packed {
        logic [NREG-1:0]         pend;
        logic [NREG-1:0][TW-1:0] tag;
        logic [NREG-1:0][DW-1:0] arch;
    } view_t;

    view_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ret_we_i) begin
            st_d.arch[ret_dst_i] = ret_value_i;
            if (st_q.pend[ret_dst_i] && st_q.tag[ret_dst_i] == ret_tag_i) begin
                st_d.pend[ret_dst_i] = 1'b0;
            end
        end
        if (flush_i) begin
            st_d.pend = '0;
        end else if (map_i) begin
            st_d.pend[map_dst_i] = 1'b1;
            st_d.tag[map_dst_i]  = map_tag_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rd_pending_o = st_q.pend[rd_reg_i];
    assign rd_tag_o     = st_q.tag[rd_reg_i];
    assign rd_arch_o    = st_q.arch[rd_reg_i];

endmodule

// File: rtl/rob_commit_unit.sv
module rob_commit_unit
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NREG  = 16,
    parameter int DW    = 32,
    parameter int TW    = $clog2(DEPTH),
    parameter int AW    = $clog2(NREG)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          alloc_valid_i,
    input  logic [AW-1:0] alloc_dst_i,
    input  logic          alloc_branch_i,
    output logic          alloc_ready_o,
    output logic [TW-1:0] alloc_tag_o,
    input  logic          cpl_valid_i,
    input  logic [TW-1:0] cpl_tag_i,
    input  logic [DW-1:0] cpl_value_i,
    input  logic          cpl_mispredict_i,
    input  logic [AW-1:0] src_reg_i,
    output logic          src_ready_o,
    output logic [TW-1:0] src_tag_o,
    output logic [DW-1:0] src_value_o,
    output logic          commit_valid_o,
    output logic          commit_wen_o,
    output logic [AW-1:0] commit_dst_o,
    output logic [TW-1:0] commit_tag_o,
    output logic [DW-1:0] commit_value_o,
    output logic          flush_o
);

    logic          full;
    logic [TW-1:0] head_idx, tail_idx;
    logic          alloc_fire, retire_fire;
    logic          h_valid, h_done, h_branch, h_mispred;
    logic [AW-1:0] h_dst;
    logic [DW-1:0] h_value;
    logic          rd_done;
    logic [DW-1:0] rd_value;
    logic          map_pend;
    logic [TW-1:0] map_tag;
    logic [DW-1:0] arch_value;
    ret_kind_e     kind;

    always_comb begin
        if (!h_valid || !h_done) kind = RET_NONE;
        else if (!h_branch)      kind = RET_REG;
        else if (h_mispred)      kind = RET_FLUSH;
        else                     kind = RET_BRANCH;
    end

    assign retire_fire    = (kind != RET_NONE);
    assign flush_o        = (kind == RET_FLUSH);
    assign commit_valid_o = retire_fire;
    assign commit_wen_o   = (kind == RET_REG);
    assign commit_dst_o   = h_dst;
    assign commit_tag_o   = head_idx;
    assign commit_value_o = h_value;

    assign alloc_ready_o  = !full && !flush_o;
    assign alloc_fire     = alloc_valid_i && alloc_ready_o;
    assign alloc_tag_o    = tail_idx;

    assign src_tag_o      = map_tag;
    assign src_ready_o    = !map_pend || rd_done;
    assign src_value_o    = map_pend ? rd_value : arch_value;

    rob_ptr_ctrl #(.DEPTH(DEPTH), .TW(TW)) u_ptr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .alloc_i    (alloc_fire),
        .retire_i   (retire_fire),
        .flush_i    (flush_o),
        .head_idx_o (head_idx),
        .tail_idx_o (tail_idx),
        .full_o     (full)
    );

    rob_entry_array #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .TW(TW)) u_ent (
        .clk_i            (clk_i),
        .rst_ni           (rst_ni),
        .flush_i          (flush_o),
        .alloc_i          (alloc_fire),
        .alloc_idx_i      (tail_idx),
        .alloc_dst_i      (alloc_dst_i),
        .alloc_branch_i   (alloc_branch_i),
        .cpl_i            (cpl_valid_i),
        .cpl_idx_i        (cpl_tag_i),
        .cpl_value_i      (cpl_value_i),
        .cpl_mispredict_i (cpl_mispredict_i),
        .retire_i         (retire_fire),
        .head_idx_i       (head_idx),
        .head_valid_o     (h_valid),
        .head_done_o      (h_done),
        .head_branch_o    (h_branch),
        .head_mispred_o   (h_mispred),
        .head_dst_o       (h_dst),
        .head_value_o     (h_value),
        .rd_idx_i         (map_tag),
        .rd_done_o        (rd_done),
        .rd_value_o       (rd_value)
    );

    rob_reg_views #(.NREG(NREG), .DW(DW), .TW(TW), .AW(AW)) u_views (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .flush_i      (flush_o),
        .map_i        (alloc_fire && !alloc_branch_i),
        .map_dst_i    (alloc_dst_i),
        .map_tag_i    (tail_idx),
        .ret_we_i     (commit_wen_o),
        .ret_dst_i    (h_dst),
        .ret_tag_i    (head_idx),
        .ret_value_i  (h_value),
        .rd_reg_i     (src_reg_i),
        .rd_pending_o (map_pend),
        .rd_tag_o     (map_tag),
        .rd_arch_o    (arch_value)
    );

endmodule

// File: rtl/rob_commit_unit_chk.sv
module rob_commit_unit_chk #(
    parameter int DEPTH = 8,
    parameter int TW    = $clog2(DEPTH)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          alloc_valid_i,
    input logic          alloc_ready_o,
    input logic [TW-1:0] alloc_tag_o,
    input logic          commit_valid_o,
    input logic          commit_wen_o,
    input logic [TW-1:0] commit_tag_o,
    input logic          flush_o
);

    logic [TW:0]   occ_q;
    logic [TW-1:0] exp_head_q;
    logic          fire;

    assign fire = alloc_valid_i && alloc_ready_o;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            occ_q      <= '0;
            exp_head_q <= '0;
        end else begin
            if (flush_o)
                occ_q <= '0;
            else
                occ_q <= occ_q + (TW+1)'(fire) - (TW+1)'(commit_valid_o);
            if (commit_valid_o) exp_head_q <= exp_head_q + 1'b1;
        end
    end

    a_r3_block_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        occ_q == (TW+1)'(DEPTH) |-> !alloc_ready_o);

    a_r3_room_when_not_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (occ_q < (TW+1)'(DEPTH) && !flush_o) |-> alloc_ready_o);

    a_r4_retire_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_valid_o |-> commit_tag_o == exp_head_q);

    a_r4_no_retire_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_valid_o |-> occ_q != '0);

    a_r2_tag_sequence: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire |=> alloc_tag_o == TW'($past(alloc_tag_o) + 1'b1));

    a_r9_refill_after_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_o |=> alloc_tag_o == TW'($past(commit_tag_o) + 1'b1));

    a_r9_flush_is_branch_retire: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_o |-> commit_valid_o && !commit_wen_o);

    a_r11_no_alloc_on_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_o |-> !alloc_ready_o);

endmodule

bind rob_commit_unit rob_commit_unit_chk #(.DEPTH(DEPTH), .TW(TW)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .alloc_valid_i  (alloc_valid_i),
    .alloc_ready_o  (alloc_ready_o),
    .alloc_tag_o    (alloc_tag_o),
    .commit_valid_o (commit_valid_o),
    .commit_wen_o   (commit_wen_o),
    .commit_tag_o   (commit_tag_o),
    .flush_o        (flush_o)
);

// File: tb/rob_commit_unit_tb_top.sv
`timescale 1ns/1ps
module rob_commit_unit_tb_top;

    localparam int DEPTH = 8;
    localparam int NREG  = 16;
    localparam int DW    = 32;
    localparam int TW    = 3;
    localparam int AW    = 4;

    typedef struct {
        logic          wen;
        logic          flush;
        logic [AW-1:0] dst;
        logic [TW-1:0] tag;
        logic [DW-1:0] val;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic          alloc_valid = 0, alloc_branch = 0;
    logic [AW-1:0] alloc_dst = '0;
    logic          alloc_ready;
    logic [TW-1:0] alloc_tag;
    logic          cpl_valid = 0, cpl_mis = 0;
    logic [TW-1:0] cpl_tag = '0;
    logic [DW-1:0] cpl_value = '0;
    logic [AW-1:0] src_reg = '0;
    logic          src_ready;
    logic [TW-1:0] src_tag;
    logic [DW-1:0] src_value;
    logic          commit_valid, commit_wen, flush;
    logic [AW-1:0] commit_dst;
    logic [TW-1:0] commit_tag;
    logic [DW-1:0] commit_value;

    int checks = 0;
    int errors = 0;
    exp_t exp_q[$];
    logic [DW-1:0] arf_m [NREG];
    logic [TW-1:0] exp_tail = '0;

    always #4 clk = ~clk;

    rob_commit_unit #(.DEPTH(DEPTH), .NREG(NREG), .DW(DW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .alloc_valid_i(alloc_valid), .alloc_dst_i(alloc_dst), .alloc_branch_i(alloc_branch),
        .alloc_ready_o(alloc_ready), .alloc_tag_o(alloc_tag),
        .cpl_valid_i(cpl_valid), .cpl_tag_i(cpl_tag), .cpl_value_i(cpl_value),
        .cpl_mispredict_i(cpl_mis),
        .src_reg_i(src_reg), .src_ready_o(src_ready), .src_tag_o(src_tag), .src_value_o(src_value),
        .commit_valid_o(commit_valid), .commit_wen_o(commit_wen), .commit_dst_o(commit_dst),
        .commit_tag_o(commit_tag), .commit_value_o(commit_value), .flush_o(flush)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic do_alloc(input logic [AW-1:0] dst, input bit br, input logic [DW-1:0] val,
                            input bit retires, input bit mis, output logic [TW-1:0] tag);
        exp_t it;
        @(negedge clk);
        alloc_valid = 1; alloc_dst = dst; alloc_branch = br;
        #1;
        tag = alloc_tag;
        chk(alloc_ready == 1'b1, "R2", "alloc ready", DW'(alloc_ready), 1);
        chk(alloc_tag == exp_tail, "R2", "alloc tag", DW'(alloc_tag), DW'(exp_tail));
        if (retires) begin
            it.wen = !br; it.flush = br && mis; it.dst = dst; it.tag = alloc_tag; it.val = val;
            exp_q.push_back(it);
            if (!br) arf_m[dst] = val;
        end
        exp_tail = exp_tail + 1'b1;
        @(posedge clk); #1;
        alloc_valid = 0; alloc_branch = 0;
    endtask

    task automatic do_cpl(input logic [TW-1:0] tag, input logic [DW-1:0] val, input bit mis);
        @(negedge clk);
        cpl_valid = 1; cpl_tag = tag; cpl_value = val; cpl_mis = mis;
        @(posedge clk); #1;
        cpl_valid = 0; cpl_mis = 0;
    endtask

    task automatic look(input logic [AW-1:0] r, output logic rdy,
                        output logic [TW-1:0] tg, output logic [DW-1:0] v);
        @(negedge clk);
        src_reg = r;
        #1;
        rdy = src_ready; tg = src_tag; v = src_value;
    endtask

    task automatic drain(input int left);
        for (int i = 0; i < 60 && exp_q.size() > left; i++) @(posedge clk);
        @(negedge clk); #3;
        chk(exp_q.size() == left, "R4", "pending retirements", DW'(exp_q.size()), DW'(left));
    endtask

    // Monitor: pops the scoreboard on every retirement
    initial begin
        forever begin
            @(negedge clk); #3;
            if (rst_n && commit_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R9", "unexpected retirement tag", DW'(commit_tag), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(commit_tag == e.tag, "R4", "retire tag", DW'(commit_tag), DW'(e.tag));
                    chk(commit_wen == e.wen, "R5", "retire wen", DW'(commit_wen), DW'(e.wen));
                    chk(flush == e.flush, "R9/R10", "flush", DW'(flush), DW'(e.flush));
                    if (e.wen) begin
                        chk(commit_dst == e.dst, "R5", "retire dst", DW'(commit_dst), DW'(e.dst));
                        chk(commit_value == e.val, "R5", "retire value", commit_value, e.val);
                    end
                end
            end
            if (rst_n && flush)
                chk(alloc_ready == 1'b0, "R11", "ready during flush", DW'(alloc_ready), 0);
        end
    end

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic rdy;
        logic [TW-1:0] tg, ta, tb, tc, td, te, tf, tk, tgg, th, ti, tj, tn;
        logic [DW-1:0] v;
        logic [TW-1:0] ftag [DEPTH+1];
        logic [DW-1:0] fval [DEPTH+1];
        for (int i = 0; i < NREG; i++) arf_m[i] = '0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        @(negedge clk); #1;
        chk(alloc_ready == 1, "R1", "ready", DW'(alloc_ready), 1);
        chk(alloc_tag == 0, "R1", "tag", DW'(alloc_tag), 0);
        chk(commit_valid == 0 && flush == 0, "R1", "retire/flush", DW'({commit_valid, flush}), 0);
        look(4'd3, rdy, tg, v);
        chk(rdy == 1 && v == 0, "R1", "lookup r3", v, 0);

        // R2/R4/R7: out-of-order completion, in-order retirement
        do_alloc(4'd1, 0, 32'hA0A0_0001, 1, 0, ta);
        do_alloc(4'd2, 0, 32'hB0B0_0002, 1, 0, tb);
        do_alloc(4'd3, 0, 32'hC0C0_0003, 1, 0, tc);
        look(4'd1, rdy, tg, v);
        chk(rdy == 0, "R7", "r1 not ready", DW'(rdy), 0);
        chk(tg == ta, "R7", "r1 producer tag", DW'(tg), DW'(ta));
        do_cpl(tc, 32'hC0C0_0003, 0);
        do_cpl(tb, 32'hB0B0_0002, 0);
        repeat (2) @(negedge clk);
        #3 chk(commit_valid == 0, "R4", "younger done, head not done", DW'(commit_valid), 0);
        look(4'd3, rdy, tg, v);
        chk(rdy == 1 && v == 32'hC0C0_0003, "R7", "r3 forwarded before retire", v, 32'hC0C0_0003);
        do_cpl(ta, 32'hA0A0_0001, 0);
        drain(0);
        look(4'd1, rdy, tg, v);
        chk(rdy == 1 && v == 32'hA0A0_0001, "R6", "r1 committed", v, 32'hA0A0_0001);

        // R8: two producers of r5
        do_alloc(4'd5, 0, 32'h5555_0001, 1, 0, td);
        do_alloc(4'd5, 0, 32'h5555_0002, 1, 0, te);
        look(4'd5, rdy, tg, v);
        chk(tg == te && rdy == 0, "R8", "youngest producer", DW'(tg), DW'(te));
        do_cpl(td, 32'h5555_0001, 0);
        drain(1);
        look(4'd5, rdy, tg, v);
        chk(rdy == 0 && tg == te, "R8", "older retire keeps map", DW'({rdy, tg}), DW'({1'b0, te}));
        do_cpl(te, 32'h5555_0002, 0);
        drain(0);
        look(4'd5, rdy, tg, v);
        chk(rdy == 1 && v == 32'h5555_0002, "R6", "r5 committed", v, 32'h5555_0002);

        // R10: correctly predicted branch
        do_alloc(4'd0, 1, 32'h0, 1, 0, tf);
        do_cpl(tf, 32'h0, 0);
        drain(0);

        // R3: full buffer
        for (int i = 0; i < DEPTH; i++)
            do_alloc(4'd10, 0, 32'hF000_0000 + 32'(i), 1, 0, ftag[i]);
        for (int i = 0; i < DEPTH; i++) fval[i] = 32'hF000_0000 + 32'(i);
        @(negedge clk);
        alloc_valid = 1; alloc_dst = 4'd11;
        #1 chk(alloc_ready == 0, "R3", "ready when full", DW'(alloc_ready), 0);
        @(posedge clk); #1 alloc_valid = 0;
        look(4'd11, rdy, tg, v);
        chk(rdy == 1 && v == arf_m[11], "R3", "ignored alloc left r11", DW'(rdy), 1);
        do_cpl(ftag[0], fval[0], 0);
        drain(DEPTH - 1);
        do_alloc(4'd12, 0, 32'hF000_00FF, 1, 0, ftag[DEPTH]);
        fval[DEPTH] = 32'hF000_00FF;
        for (int i = DEPTH; i >= 1; i--) do_cpl(ftag[i], fval[i], 0);
        drain(0);

        // R9: mispredicted branch
        do_alloc(4'd8, 0, 32'h8888_0008, 1, 0, tk);
        do_cpl(tk, 32'h8888_0008, 0);
        drain(0);
        do_alloc(4'd7, 0, 32'h7777_0007, 1, 0, tgg);
        do_alloc(4'd0, 1, 32'h0, 1, 1, th);
        do_alloc(4'd8, 0, 32'hDEAD_0008, 0, 0, ti);
        do_alloc(4'd9, 0, 32'hDEAD_0009, 0, 0, tj);
        do_cpl(tj, 32'hDEAD_0009, 0);
        do_cpl(ti, 32'hDEAD_0008, 0);
        do_cpl(tgg, 32'h7777_0007, 0);
        do_cpl(th, 32'h0, 1);
        drain(0);
        repeat (3) @(negedge clk);
        #3 chk(commit_valid == 0, "R9", "discarded entries stay gone", DW'(commit_valid), 0);
        look(4'd8, rdy, tg, v);
        chk(rdy == 1 && v == 32'h8888_0008, "R9", "r8 restored", v, 32'h8888_0008);
        look(4'd9, rdy, tg, v);
        chk(rdy == 1 && v == arf_m[9], "R9", "r9 restored", v, arf_m[9]);
        exp_tail = th + 1'b1;
        do_alloc(4'd9, 0, 32'h9999_0009, 1, 0, tn);
        do_cpl(tn, 32'h9999_0009, 0);
        drain(0);
        look(4'd9, rdy, tg, v);
        chk(rdy == 1 && v == 32'h9999_0009, "R6", "r9 after refill", v, 32'h9999_0009);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule